// File: doc/BRIEF.md
# DTMF Burst Transmit Pacer

This block paces a DTMF transmitter that runs in burst mode. When a digit is written to its transmit port, it drives a tone-enable signal for a burst period and then holds the line silent for a pause period of the same nominal length. Only when the pause is over does it raise a transmit-ready flag and, if interrupts are enabled, an interrupt request. The block never produces tones itself. It presents the latched digit and the tone-enable to a downstream synthesiser.

Timing is counted in millisecond ticks, which come from a clock divider whose ratio is a parameter. The divider is restarted at the start of every burst, so each phase lasts exactly its nominal number of ticks. A mode input chosen at the start of a burst selects either the normal timing of 50 ms tone and 50 ms silence, or an extended timing that doubles both phases. The block also keeps a receive-ready flag. A strobe from the external DTMF detector sets it, and a read of the receive data clears it. Reading status clears the transmit-ready flag and the interrupt.

Top module: `dtmf_burst_pacer`

## Requirements
- R1: After reset, tone_on, tx_ready, rx_ready and irq are 0 and tone_digit is 0.
- R2: A tx_wr while idle latches tx_digit onto tone_digit, and tone_on goes high from the next cycle for exactly BURST_MS*CLK_PER_TICK cycles.
- R3: After the burst, tone_on stays low for PAUSE_MS*CLK_PER_TICK cycles. tx_ready rises exactly (BURST_MS+PAUSE_MS)*CLK_PER_TICK cycles after the edge that accepted the write, and is 0 before that.
- R4: ext_mode is sampled when a burst starts. When it is 1, both the burst and the pause are doubled. Changing ext_mode during a burst or pause has no effect on that cycle.
- R5: A tx_wr during a burst or pause does not change tone_digit or the running timing. The latest such digit is held, and it starts a new burst on the edge where the pause ends. In that case tx_ready is not set.
- R6: rx_strobe sets rx_ready and rx_rd clears it. When both occur in the same cycle, rx_ready is set.
- R7: stat_rd clears tx_ready and irq. When a set event occurs in the same cycle, the set wins.
- R8: irq is set when tx_ready or rx_ready is set while irq_en is 1. With irq_en at 0, those events leave irq at 0.
- R9: tone_on and tx_ready are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | One-cycle strobe that writes a transmit digit |
| tx_digit | input | DIGIT_W | Digit code to transmit |
| ext_mode | input | 1 | 1 selects extended (doubled) burst timing |
| rx_strobe | input | 1 | Detector strobe: a received digit is available |
| rx_rd | input | 1 | Strobe: receive data has been read |
| stat_rd | input | 1 | Strobe: status has been read |
| irq_en | input | 1 | Enables the interrupt request |
| tone_on | output | 1 | Tone enable for the synthesiser |
| tone_digit | output | DIGIT_W | Digit currently being sent |
| tx_ready | output | 1 | Transmit-ready status flag |
| rx_ready | output | 1 | Receive-ready status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every strobe input lasts one clock and is sampled on the rising edge. They also assume that reset is held long enough for the divider and the flags to settle. The millisecond tick is taken to be the only thing that advances the phase counter, so the bounds on the counter hold only while CLK_PER_TICK is at least 2. The bench drives all inputs on the falling edge as single-cycle pulses. It changes ext_mode only outside the edge that starts a burst, except where it checks on purpose that a change made during a burst is ignored. This keeps every cycle count it expects exact.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BURST = 2'd1,
      PH_PAUSE = 2'd2
   } phase_t;
endpackage

// File: rtl/dbp_tick_gen.sv
module dbp_tick_gen #(
   parameter int CLK_PER_TICK = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int DIV_W = (CLK_PER_TICK < 2) ? 1 : $clog2(CLK_PER_TICK);
   localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_TICK - 1);
   localparam bit POW2 = ((CLK_PER_TICK & (CLK_PER_TICK - 1)) == 0);

   logic [DIV_W-1:0] div_q;

   generate
      if (POW2) begin : g_wrap
         // Power-of-two ratio: the counter simply wraps.
         always_ff @(posedge clk) begin
            if (!rst_n || restart) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
         end
         assign tick = &div_q;
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || restart)  div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate

   // The divider must never pass its last count (sets the R2 burst length).
   assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      div_q <= LAST);
endmodule

// File: rtl/dbp_burst_seq.sv
module dbp_burst_seq
   import dbp_pkg::*;
#(
   parameter int DIGIT_W  = 4,
   parameter int BURST_MS = 50,
   parameter int PAUSE_MS = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr,
   input  logic [DIGIT_W-1:0] wr_digit,
   input  logic               ext_in,
   output logic               restart,
   output logic               tone_on,
   output logic [DIGIT_W-1:0] tone_digit,
   output logic               tx_start,
   output logic               tx_done
);
   localparam int LONGEST = (BURST_MS > PAUSE_MS) ? BURST_MS : PAUSE_MS;
   localparam int MS_W    = $clog2(2 * LONGEST + 1);
   localparam logic [MS_W-1:0] B_N = MS_W'(BURST_MS);
   localparam logic [MS_W-1:0] B_X = MS_W'(2 * BURST_MS);
   localparam logic [MS_W-1:0] P_N = MS_W'(PAUSE_MS);
   localparam logic [MS_W-1:0] P_X = MS_W'(2 * PAUSE_MS);

   phase_t             phase_q;
   logic [MS_W-1:0]    ms_q;
   logic               ext_q;
   logic [DIGIT_W-1:0] digit_q;
   logic               pend_v_q;
   logic [DIGIT_W-1:0] pend_d_q;

   logic [MS_W-1:0]    cur_lim;
   logic               last_ms;
   logic               end_cycle;
   logic               has_next;
   logic               start;
   logic [DIGIT_W-1:0] next_digit;

   always_comb begin
      if (phase_q == PH_BURST) cur_lim = ext_q ? B_X : B_N;
      else                     cur_lim = ext_q ? P_X : P_N;
      last_ms    = tick && (ms_q == cur_lim - 1'b1);
      end_cycle  = (phase_q == PH_PAUSE) && last_ms;
      has_next   = pend_v_q || wr;
      start      = ((phase_q == PH_IDLE) && wr) || (end_cycle && has_next);
      next_digit = wr ? wr_digit : pend_d_q;
   end

   assign restart    = start;
   assign tx_start   = start;
   assign tx_done    = end_cycle && !has_next;
   assign tone_on    = (phase_q == PH_BURST);
   assign tone_digit = digit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         ms_q     <= '0;
         ext_q    <= 1'b0;
         digit_q  <= '0;
         pend_v_q <= 1'b0;
         pend_d_q <= '0;
      end else if (start) begin
         phase_q  <= PH_BURST;
         ms_q     <= '0;
         digit_q  <= next_digit;
         ext_q    <= ext_in;
         pend_v_q <= 1'b0;
      end else begin
         if (wr && phase_q != PH_IDLE) begin
            pend_v_q <= 1'b1;
            pend_d_q <= wr_digit;
         end
         if (phase_q != PH_IDLE && tick) begin
            if (last_ms) begin
               ms_q    <= '0;
               phase_q <= (phase_q == PH_BURST) ? PH_PAUSE : PH_IDLE;
            end else begin
               ms_q <= ms_q + 1'b1;
            end
         end
      end
   end

   // While a phase is running, the millisecond count stays below that phase's length.
   assert_ms_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |-> (ms_q < cur_lim));
   // The digit on the line holds for the whole of a burst.
   assert_digit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_on && $past(tone_on)) |-> $stable(tone_digit));
   // The extended setting is frozen for the whole of a burst.
   assert_ext_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_on && $past(tone_on)) |-> $stable(ext_q));
endmodule

// File: rtl/dbp_status_flags.sv
module dbp_status_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_done,
   input  logic tx_start,
   input  logic stat_rd,
   input  logic rx_strobe,
   input  logic rx_rd,
   input  logic irq_en,
   output logic tx_ready,
   output logic rx_ready,
   output logic irq
);
   logic irq_set;
   assign irq_set = irq_en && (tx_done || rx_strobe);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ready <= 1'b0;
         rx_ready <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (tx_done)                  tx_ready <= 1'b1;
         else if (stat_rd || tx_start) tx_ready <= 1'b0;
         if (rx_strobe)                rx_ready <= 1'b1;
         else if (rx_rd)               rx_ready <= 1'b0;
         if (irq_set)                  irq <= 1'b1;
         else if (stat_rd)             irq <= 1'b0;
      end
   end

   assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> tx_ready);
   assert_rx_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> rx_ready);
   assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !tx_done) |=> !tx_ready);
   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !irq) |=> !irq);
endmodule

// File: rtl/dtmf_burst_pacer.sv
module dtmf_burst_pacer #(
   parameter int DIGIT_W      = 4,
   parameter int CLK_PER_TICK = 1000,
   parameter int BURST_MS     = 50,
   parameter int PAUSE_MS     = 50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_wr,
   input  logic [DIGIT_W-1:0] tx_digit,
   input  logic               ext_mode,
   input  logic               rx_strobe,
   input  logic               rx_rd,
   input  logic               stat_rd,
   input  logic               irq_en,
   output logic               tone_on,
   output logic [DIGIT_W-1:0] tone_digit,
   output logic               tx_ready,
   output logic               rx_ready,
   output logic               irq
);
   generate
      if (CLK_PER_TICK < 2) begin : g_bad_div
         $error("CLK_PER_TICK must be at least 2");
      end
      if (BURST_MS < 1 || PAUSE_MS < 1) begin : g_bad_ms
         $error("BURST_MS and PAUSE_MS must be at least 1");
      end
      if (DIGIT_W < 1) begin : g_bad_w
         $error("DIGIT_W must be at least 1");
      end
   endgenerate

   logic tick;
   logic restart;
   logic tx_start;
   logic tx_done;

   dbp_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   dbp_burst_seq #(
      .DIGIT_W  (DIGIT_W),
      .BURST_MS (BURST_MS),
      .PAUSE_MS (PAUSE_MS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .wr         (tx_wr),
      .wr_digit   (tx_digit),
      .ext_in     (ext_mode),
      .restart    (restart),
      .tone_on    (tone_on),
      .tone_digit (tone_digit),
      .tx_start   (tx_start),
      .tx_done    (tx_done)
   );

   dbp_status_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_done   (tx_done),
      .tx_start  (tx_start),
      .stat_rd   (stat_rd),
      .rx_strobe (rx_strobe),
      .rx_rd     (rx_rd),
      .irq_en    (irq_en),
      .tx_ready  (tx_ready),
      .rx_ready  (rx_ready),
      .irq       (irq)
   );

   assert_tone_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tone_on && tx_ready));
endmodule

// File: tb/dtmf_burst_pacer_tb_top.sv
module dtmf_burst_pacer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CPT = 4;
   localparam int BMS = 50;
   localparam int PMS = 50;
   localparam int BC  = BMS * CPT;
   localparam int PC  = PMS * CPT;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_wr = 1'b0, ext_mode = 1'b0, rx_strobe = 1'b0, rx_rd = 1'b0;
   logic stat_rd = 1'b0, irq_en = 1'b0;
   logic [3:0] tx_digit = '0;
   logic tone_on, tx_ready, rx_ready, irq;
   logic [3:0] tone_digit;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dtmf_burst_pacer #(.DIGIT_W(4), .CLK_PER_TICK(CPT), .BURST_MS(BMS), .PAUSE_MS(PMS)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_digit(tx_digit), .ext_mode(ext_mode),
      .rx_strobe(rx_strobe), .rx_rd(rx_rd), .stat_rd(stat_rd), .irq_en(irq_en),
      .tone_on(tone_on), .tone_digit(tone_digit), .tx_ready(tx_ready),
      .rx_ready(rx_ready), .irq(irq));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic wait_to(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   // Write a digit; returns after the accepting edge, giving that edge's number.
   task automatic do_write(input logic [3:0] d, input logic ext, output int edge_n);
      @(negedge clk);
      tx_wr = 1'b1; tx_digit = d; ext_mode = ext;
      @(negedge clk);
      tx_wr = 1'b0;
      edge_n = cyc;
   endtask

   task automatic pulse_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 tone_on", int'(tone_on), 0);
      chk("R1 tx_ready", int'(tx_ready), 0);
      chk("R1 rx_ready", int'(rx_ready), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 tone_digit", int'(tone_digit), 0);
   endtask

   task automatic t_normal();
      int w0;
      irq_en = 1'b1;
      do_write(4'd7, 1'b0, w0);
      chk("R2 digit", int'(tone_digit), 7);
      chk("R2 tone start", int'(tone_on), 1);
      chk("R9 ready low in burst", int'(tx_ready), 0);
      wait_to(w0 + BC - 1); chk("R2 tone last", int'(tone_on), 1);
      wait_to(w0 + BC);     chk("R2 tone end", int'(tone_on), 0);
      wait_to(w0 + BC + PC - 1);
      chk("R3 silent", int'(tone_on), 0);
      chk("R3 ready early", int'(tx_ready), 0);
      wait_to(w0 + BC + PC);
      chk("R3 ready", int'(tx_ready), 1);
      chk("R8 irq on tx", int'(irq), 1);
      pulse_stat();
      chk("R7 ready cleared", int'(tx_ready), 0);
      chk("R7 irq cleared", int'(irq), 0);
   endtask

   task automatic t_extended();
      int w0;
      irq_en = 1'b1;
      do_write(4'd5, 1'b1, w0);
      ext_mode = 1'b0; // change mid-burst: must be ignored
      wait_to(w0 + 2*BC - 1); chk("R4 ext tone", int'(tone_on), 1);
      wait_to(w0 + 2*BC);     chk("R4 ext tone end", int'(tone_on), 0);
      wait_to(w0 + 2*BC + 2*PC - 1); chk("R4 ext ready early", int'(tx_ready), 0);
      wait_to(w0 + 2*BC + 2*PC);     chk("R4 ext ready", int'(tx_ready), 1);
      pulse_stat();
   endtask

   task automatic t_pending();
      int w0, wx;
      irq_en = 1'b0;
      do_write(4'd3, 1'b0, w0);
      wait_to(w0 + 10);
      do_write(4'd9, 1'b0, wx);
      chk("R5 digit kept", int'(tone_digit), 3);
      wait_to(w0 + BC + 20);
      do_write(4'd10, 1'b0, wx);
      wait_to(w0 + BC + PC - 1);
      chk("R5 old digit", int'(tone_digit), 3);
      chk("R5 still silent", int'(tone_on), 0);
      wait_to(w0 + BC + PC);
      chk("R5 held digit starts", int'(tone_on), 1);
      chk("R5 latest digit", int'(tone_digit), 10);
      chk("R5 no ready", int'(tx_ready), 0);
      wait_to(w0 + 2*(BC + PC));
      chk("R5 second ready", int'(tx_ready), 1);
      chk("R8 irq disabled", int'(irq), 0);
      pulse_stat();
   endtask

   task automatic t_receive();
      irq_en = 1'b1;
      @(negedge clk); rx_strobe = 1'b1;
      @(negedge clk); rx_strobe = 1'b0;
      chk("R6 rx set", int'(rx_ready), 1);
      chk("R8 irq on rx", int'(irq), 1);
      pulse_stat();
      chk("R7 irq cleared, rx kept", int'(irq), 0);
      chk("R6 rx kept by stat_rd", int'(rx_ready), 1);
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
      chk("R6 rx cleared", int'(rx_ready), 0);
      @(negedge clk); rx_rd = 1'b1; rx_strobe = 1'b1; stat_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0; rx_strobe = 1'b0; stat_rd = 1'b0;
      chk("R6 set wins", int'(rx_ready), 1);
      chk("R7 set wins irq", int'(irq), 1);
      pulse_stat();
      irq_en = 1'b0;
      @(negedge clk); rx_strobe = 1'b1;
      @(negedge clk); rx_strobe = 1'b0;
      chk("R8 no irq when disabled", int'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_normal();
      t_extended();
      t_pending();
      t_receive();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule